// File: doc/BRIEF.md
# Triggered Fixed-Count I2C Reader

This block fetches one byte from an I2C sensor each time it is triggered, with no processor involved. A single cycle counter in the block steps through the whole transaction. The counter's value is compared against fixed slot positions to choose what the bus does at each moment. The transaction always has the same shape. It begins with a start condition. It then sends the device address with the write bit and the register pointer. A repeated start follows, then the device address with the read bit. Eight data bits are then clocked in from the sensor. The block answers with a not-acknowledge and closes with a stop condition. Both bus lines are open drain. The block only asserts "pull low" enables and never drives a line high.

Each bus bit takes four clock cycles, called quarters. SCL is released during the second and third quarters. The block changes SDA only at the start of the first quarter, which is the middle of the SCL low time. The one exception is the start and stop slots, where SDA moves at the third quarter while SCL is high. The sequencer has three states. `ST_IDLE` leaves both lines released. The `go` transition, taken when `trigger` is high, leads to `ST_RUN`, where the counter advances once per clock. The `finish` transition, taken when the counter reaches the last quarter of the stop slot, leads to `ST_DONE`. That state lasts one cycle, raises `done` and loads the captured byte. The `rearm` transition then returns unconditionally to `ST_IDLE`. The bus decoder sorts each bit slot into one of six kinds: `SL_START`, `SL_CMD`, `SL_ACK`, `SL_RX`, `SL_NACK` and `SL_STOP`.

Top module: `i2c_fixed_reader`

## Requirements
- R1: After reset, and whenever `busy` is low, `scl_low` and `sda_low` are both 0 and `done` is 0. `rd_data` resets to 0.
- R2: A high `trigger` sampled in `ST_IDLE` makes `busy` 1 on the next cycle. The transaction then runs to its end whatever `trigger` does.
- R3: Every SCL rising edge during a transaction comes exactly 4 clock cycles after the previous one. SDA changes while SCL is high only for exactly two start conditions and one stop condition per transaction.
- R4: Bytes go out MSB first in this order: start, then {`dev_addr`, 0}, then `reg_ptr`, then a repeated start, then {`dev_addr`, 1}.
- R5: During the ninth bit after each of the three command bytes, `sda_low` is 0. Whatever the sensor drives in that bit has no effect on the transaction or on the captured byte.
- R6: The 8 bits the sensor returns are sampled while SCL is high and assembled MSB first. They appear on `rd_data` when `done` is 1.
- R7: After the data byte, SDA stays released for one bit (not-acknowledge). A stop condition follows, and both lines stay released afterwards.
- R8: `done` is a one-cycle pulse. It is visible 156 clock edges after the edge that accepted the trigger (39 bit slots of 4 cycles). `busy` is 0 on the cycle after `done`.
- R9: A trigger sampled while `busy` is 1, including the `done` cycle, is ignored. It causes no extra start condition and no new transaction.
- R10: `rd_data` changes only in a cycle where `done` is 1. It holds its value through the whole next transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, four times the SCL bit rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| trigger | input | 1 | Starts a transaction when the block is idle |
| sda_in | input | 1 | Level sensed on the SDA line |
| dev_addr | input | ADDR_W (7) | Sensor bus address |
| reg_ptr | input | PTR_W (8) | Sensor register to read |
| scl_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_low | output | 1 | 1 pulls SDA low, 0 releases it |
| rd_data | output | DATA_W (8) | Last byte read from the sensor |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| busy | output | 1 | High from trigger acceptance until `done` ends |

## Verification
Two things can land in the same cycle: the `done` pulse with its result load, and a fresh trigger pulse. The bench raises `trigger` so that it is sampled exactly in the `done` cycle. It expects `busy` to fall on the next cycle, both lines to stay released, and no start condition to appear, while `rd_data` keeps the byte just loaded. A second overlap comes from a sensor model that pulls SDA low during the acknowledge bits. This happens in the same bit slots where the block itself releases SDA. The check is that neither the command bytes nor the captured byte are disturbed.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DONE
    } rd_state_e;

    typedef enum logic [2:0] {
        SL_START,
        SL_CMD,
        SL_ACK,
        SL_RX,
        SL_NACK,
        SL_STOP
    } slot_kind_e;

    // clock cycles per bus bit slot
    localparam int QUARTERS = 4;

endpackage

// File: rtl/i2c_rd_seq.sv
module i2c_rd_seq
    import i2c_rd_pkg::*;
#(
    parameter int N_SLOTS = 39,
    localparam int CW = $clog2(N_SLOTS * QUARTERS + 1),
    localparam int SW = CW - 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trigger,
    output logic [SW-1:0] slot,
    output logic [1:0]    qtr,
    output logic          run,
    output logic          busy,
    output logic          done,
    output logic          finish
);

    localparam logic [CW-1:0] LAST = CW'(N_SLOTS * QUARTERS - 1);

    rd_state_e      state, state_nx;
    logic [CW-1:0]  cnt;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (trigger) state_nx = ST_RUN;         // go
            ST_RUN:  if (cnt == LAST) state_nx = ST_DONE;    // finish
            ST_DONE: state_nx = ST_IDLE;                     // rearm
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_RUN) cnt <= cnt + 1'b1;
            else                 cnt <= '0;
        end
    end

    always_comb begin
        run    = (state == ST_RUN);
        busy   = (state != ST_IDLE);
        done   = (state == ST_DONE);
        finish = run && (cnt == LAST);
        slot   = cnt[CW-1:2];
        qtr    = cnt[1:0];
    end

endmodule

// File: rtl/i2c_rd_bus.sv
module i2c_rd_bus
    import i2c_rd_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int PTR_W   = 8,
    parameter int SW      = 6,
    parameter int S_ADDR1 = 1,
    parameter int S_ACK1  = 9,
    parameter int S_PTR   = 10,
    parameter int S_ACK2  = 18,
    parameter int S_RS    = 19,
    parameter int S_ADDR2 = 20,
    parameter int S_ACK3  = 28,
    parameter int S_NACK  = 37
) (
    input  logic              run,
    input  logic [SW-1:0]     slot,
    input  logic [1:0]        qtr,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic [PTR_W-1:0]  reg_ptr,
    output logic              scl_low,
    output logic              sda_low,
    output logic              sample
);

    localparam int FW = ADDR_W + 1;
    localparam logic [SW-1:0] K_ADDR1 = SW'(S_ADDR1);
    localparam logic [SW-1:0] K_ACK1  = SW'(S_ACK1);
    localparam logic [SW-1:0] K_PTR   = SW'(S_PTR);
    localparam logic [SW-1:0] K_ACK2  = SW'(S_ACK2);
    localparam logic [SW-1:0] K_RS    = SW'(S_RS);
    localparam logic [SW-1:0] K_ADDR2 = SW'(S_ADDR2);
    localparam logic [SW-1:0] K_ACK3  = SW'(S_ACK3);
    localparam logic [SW-1:0] K_NACK  = SW'(S_NACK);

    logic [FW-1:0]    wr_frame, rd_frame, frame_sh;
    logic [PTR_W-1:0] ptr_sh;
    slot_kind_e       kind;
    logic             tx_bit;

    assign wr_frame = {dev_addr, 1'b0};
    assign rd_frame = {dev_addr, 1'b1};

    // slot decoder: comparator windows on the slot index
    always_comb begin
        kind     = SL_STOP;
        tx_bit   = 1'b1;
        frame_sh = '0;
        ptr_sh   = '0;
        if (slot == '0) begin
            kind = SL_START;
        end else if (slot < K_ACK1) begin
            kind     = SL_CMD;
            frame_sh = wr_frame << (slot - K_ADDR1);
            tx_bit   = frame_sh[FW-1];
        end else if (slot == K_ACK1) begin
            kind = SL_ACK;
        end else if (slot < K_ACK2) begin
            kind   = SL_CMD;
            ptr_sh = reg_ptr << (slot - K_PTR);
            tx_bit = ptr_sh[PTR_W-1];
        end else if (slot == K_ACK2) begin
            kind = SL_ACK;
        end else if (slot == K_RS) begin
            kind = SL_START;
        end else if (slot < K_ACK3) begin
            kind     = SL_CMD;
            frame_sh = rd_frame << (slot - K_ADDR2);
            tx_bit   = frame_sh[FW-1];
        end else if (slot == K_ACK3) begin
            kind = SL_ACK;
        end else if (slot < K_NACK) begin
            kind = SL_RX;
        end else if (slot == K_NACK) begin
            kind = SL_NACK;
        end
    end

    // line drive: SCL released in quarters 1 and 2
    always_comb begin
        scl_low = 1'b0;
        sda_low = 1'b0;
        if (run) begin
            scl_low = (qtr == 2'd0) || (qtr == 2'd3);
            unique case (kind)
                SL_START: sda_low = qtr[1];
                SL_CMD:   sda_low = !tx_bit;
                SL_STOP: begin
                    sda_low = !qtr[1];
                    scl_low = (qtr == 2'd0);
                end
                default:  sda_low = 1'b0;
            endcase
        end
    end

    assign sample = run && (kind == SL_RX) && (qtr == 2'd1);

endmodule

// File: rtl/i2c_rd_capture.sv
module i2c_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic              sda_in,
    input  logic              finish,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            rd_data <= '0;
        end else begin
            if (sample) shreg <= {shreg[DATA_W-2:0], sda_in};
            if (finish) rd_data <= shreg;
        end
    end

endmodule

// File: rtl/i2c_fixed_reader.sv
module i2c_fixed_reader
    import i2c_rd_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int PTR_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trigger,
    input  logic              sda_in,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic [PTR_W-1:0]  reg_ptr,
    output logic              scl_low,
    output logic              sda_low,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              busy
);

    localparam int S_ADDR1 = 1;
    localparam int S_ACK1  = S_ADDR1 + ADDR_W + 1;
    localparam int S_PTR   = S_ACK1 + 1;
    localparam int S_ACK2  = S_PTR + PTR_W;
    localparam int S_RS    = S_ACK2 + 1;
    localparam int S_ADDR2 = S_RS + 1;
    localparam int S_ACK3  = S_ADDR2 + ADDR_W + 1;
    localparam int S_RX    = S_ACK3 + 1;
    localparam int S_NACK  = S_RX + DATA_W;
    localparam int S_STOP  = S_NACK + 1;
    localparam int N_SLOTS = S_STOP + 1;
    localparam int CW      = $clog2(N_SLOTS * QUARTERS + 1);
    localparam int SW      = CW - 2;

    logic [SW-1:0] slot;
    logic [1:0]    qtr;
    logic          run, finish, sample;

    i2c_rd_seq #(.N_SLOTS(N_SLOTS)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .trigger (trigger),
        .slot    (slot),
        .qtr     (qtr),
        .run     (run),
        .busy    (busy),
        .done    (done),
        .finish  (finish)
    );

    i2c_rd_bus #(
        .ADDR_W  (ADDR_W),
        .PTR_W   (PTR_W),
        .SW      (SW),
        .S_ADDR1 (S_ADDR1),
        .S_ACK1  (S_ACK1),
        .S_PTR   (S_PTR),
        .S_ACK2  (S_ACK2),
        .S_RS    (S_RS),
        .S_ADDR2 (S_ADDR2),
        .S_ACK3  (S_ACK3),
        .S_NACK  (S_NACK)
    ) u_bus (
        .run      (run),
        .slot     (slot),
        .qtr      (qtr),
        .dev_addr (dev_addr),
        .reg_ptr  (reg_ptr),
        .scl_low  (scl_low),
        .sda_low  (sda_low),
        .sample   (sample)
    );

    i2c_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .sample  (sample),
        .sda_in  (sda_in),
        .finish  (finish),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/i2c_rd_checker.sv
module i2c_rd_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trigger,
    input logic              scl_low,
    input logic              sda_low,
    input logic [DATA_W-1:0] rd_data,
    input logic              done,
    input logic              busy
);

    assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_low && !sda_low && !done));

    assert_trigger_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && trigger) |=> (busy && scl_low && !sda_low));

    assert_run_continues_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    assert_done_trigger_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && trigger) |=> !busy);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_lines_free_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!scl_low && !sda_low));

    assert_data_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data != $past(rd_data)) |-> done);

endmodule

bind i2c_fixed_reader i2c_rd_checker #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .trigger (trigger),
    .scl_low (scl_low),
    .sda_low (sda_low),
    .rd_data (rd_data),
    .done    (done),
    .busy    (busy)
);

// File: tb/tb_i2c_fixed_reader.sv
module tb_i2c_fixed_reader;

    localparam int CLK_PERIOD = 10;
    localparam int EXP_LAT    = 39 * 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trigger = 1'b0;
    logic [6:0] dev_addr = '0;
    logic [7:0] reg_ptr = '0;
    logic       scl_low, sda_low, done, busy;
    logic [7:0] rd_data;
    logic       sda_in;

    logic       slave_low = 1'b0;
    logic [7:0] slave_data = '0;
    wire        scl_line = !scl_low;
    wire        sda_line = !(sda_low || slave_low);
    assign sda_in = sda_line;

    int errors = 0;
    int checks = 0;
    logic [7:0] exp_q[$];

    // monitor-owned frame statistics
    int   cyc = 0, lat_cnt = 0;
    int   starts, stops, ack_bad, rmin, rmax, last_rise;
    int   bitcnt, byteno;
    bit   in_frame, rd_ph, nack_val;
    logic [7:0] shin, wb0, wb1, rb0;
    logic scl_p = 1'b1, sda_p = 1'b1, busy_p = 1'b0;

    i2c_fixed_reader dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .trigger  (trigger),
        .sda_in   (sda_in),
        .dev_addr (dev_addr),
        .reg_ptr  (reg_ptr),
        .scl_low  (scl_low),
        .sda_low  (sda_low),
        .rd_data  (rd_data),
        .done     (done),
        .busy     (busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (trigger && !busy) lat_cnt <= 0;
        else                  lat_cnt <= lat_cnt + 1;
    end

    // bus monitor, sensor model and scoreboard
    always @(negedge clk) begin
        logic sl, sd;
        cyc++;
        sl = scl_line;
        sd = sda_line;
        if (busy && !busy_p) begin
            starts = 0; stops = 0; ack_bad = 0; rmin = 9999; rmax = 0;
            last_rise = -1; in_frame = 0; rd_ph = 0; nack_val = 0;
            wb0 = 'x; wb1 = 'x; rb0 = 'x;
        end
        if (sl && scl_p && sda_p && !sd) begin
            if (in_frame) rd_ph = 1; else begin in_frame = 1; rd_ph = 0; end
            starts++; bitcnt = 0; byteno = 0; slave_low = 0;
        end else if (sl && scl_p && !sda_p && sd) begin
            stops++; in_frame = 0; slave_low = 0;
        end
        if (sl && !scl_p) begin
            if (busy) begin
                if (last_rise >= 0) begin
                    if (cyc - last_rise < rmin) rmin = cyc - last_rise;
                    if (cyc - last_rise > rmax) rmax = cyc - last_rise;
                end
                last_rise = cyc;
            end
            if (in_frame) begin
                bitcnt++;
                if (bitcnt <= 8) shin = {shin[6:0], sd};
                if (bitcnt == 8) begin
                    if (!rd_ph && byteno == 0) wb0 = shin;
                    if (!rd_ph && byteno == 1) wb1 = shin;
                    if (rd_ph && byteno == 0)  rb0 = shin;
                end
                if (bitcnt == 9) begin
                    if (rd_ph && byteno == 1) nack_val = sd;
                    else if (sda_low) ack_bad++;
                    bitcnt = 0;
                    byteno++;
                end
            end
        end
        if (!sl && scl_p && in_frame) begin
            if (bitcnt == 8 && !(rd_ph && byteno == 1)) slave_low = 1;      // ack pulled low
            else if (rd_ph && byteno == 1 && bitcnt < 8) slave_low = !slave_data[3'(7 - bitcnt)];
            else slave_low = 0;
        end
        if (done) begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check(rd_data == e, "R6 captured byte", rd_data, e);
            check(lat_cnt == EXP_LAT, "R8 done latency", lat_cnt, EXP_LAT);
        end
        scl_p = sl; sda_p = sd; busy_p = busy;
    end

    task automatic run_txn(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d,
                           input bit mid_trig, input bit done_trig);
        logic [7:0] prev;
        prev = rd_data;
        @(negedge clk);
        dev_addr = a; reg_ptr = p; slave_data = d;
        exp_q.push_back(d);
        trigger = 1'b1;
        @(negedge clk);
        trigger = 1'b0;
        check(busy == 1'b1, "R2 busy after trigger", busy, 1);
        repeat (60) @(negedge clk);
        check(busy == 1'b1, "R2 still running", busy, 1);
        check(rd_data == prev, "R10 byte held mid-run", rd_data, prev);
        if (mid_trig) begin
            trigger = 1'b1;
            @(negedge clk);
            trigger = 1'b0;
        end
        while (!done) @(negedge clk);
        if (done_trig) trigger = 1'b1;         // sampled in the done cycle
        @(negedge clk);
        trigger = 1'b0;
        check(done == 1'b0, "R8 done one cycle", done, 0);
        check(busy == 1'b0, "R8/R9 idle after done", busy, 0);
        check(scl_low == 0 && sda_low == 0, "R7 lines released", {scl_low, sda_low}, 0);
        check(starts == 2, "R3/R9 start count", starts, 2);
        check(stops == 1, "R7 stop count", stops, 1);
        check(rmin == 4 && rmax == 4, "R3 bit period", rmax * 100 + rmin, 404);
        check(wb0 == {a, 1'b0}, "R4 write address byte", wb0, {a, 1'b0});
        check(wb1 == p, "R4 pointer byte", wb1, p);
        check(rb0 == {a, 1'b1}, "R4 read address byte", rb0, {a, 1'b1});
        check(ack_bad == 0, "R5 ack slots released", ack_bad, 0);
        check(nack_val == 1'b1, "R7 nack released", nack_val, 1);
        repeat (8) @(negedge clk);
        check(busy == 1'b0 && scl_low == 0 && sda_low == 0, "R9 no new transaction",
              {busy, scl_low, sda_low}, 0);
        check(rd_data == d, "R10 byte held after done", rd_data, d);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL R8 watchdog: transaction never completed");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(scl_low == 0 && sda_low == 0, "R1 lines released in reset", {scl_low, sda_low}, 0);
        check(busy == 0 && done == 0, "R1 idle flags", {busy, done}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(rd_data == 8'h00, "R1 byte reset", rd_data, 0);
        check(busy == 0 && scl_low == 0, "R1 idle after reset", {busy, scl_low}, 0);
        run_txn(7'h48, 8'h00, 8'h19, 1'b0, 1'b0);
        run_txn(7'h4D, 8'hA5, 8'hE7, 1'b1, 1'b0);
        run_txn(7'h7F, 8'hFF, 8'h00, 1'b0, 1'b1);
        run_txn(7'h00, 8'h01, 8'hFF, 1'b1, 1'b1);
        check(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule